// File: doc/BRIEF.md
# Decimal-capable add and status-flag unit

This unit is the arithmetic and status core of a small accumulator machine. It adds an operand and the carry flag to the accumulator. The addition is plain binary when the decimal flag is clear. When the decimal flag is set, the addition is packed BCD, one 4-bit digit per nibble, and digit carries ripple upward. The unit also holds the machine's status register, made of seven flags plus one constant bit. Add results and load results update the flags, and explicit set commands change single flags.

A controller drives the accumulator value, the operand and a 3-bit command, and pulses an enable for one clock per command. The sum is combinational and can be read in the same cycle. The status register changes on the clock edge at which the enable is sampled high. A second status output gives the byte a break sequence writes to the stack: it is the current status with the break bit and bit 5 forced high. Reset is asynchronous active-low and is released through a two-stage synchronizer.

Top module: `flag_bcd_alu`

## Requirements
- R1: With decimal mode off, command ADC (code 1) gives `result_o` = (acc + operand + C) mod 2^DATA_W. After the enabled edge, C (status bit 0) equals the carry out of the top bit.
- R2: After an enabled ADC, Z (status bit 1) is 1 exactly when the DATA_W-bit result was zero.
- R3: After an enabled ADC, V (status bit 6) is 1 exactly when the signed binary sum of acc, operand and carry-in falls outside the signed DATA_W-bit range. For example, 0x40 + 0x40 sets V.
- R4: After an enabled ADC, N (status bit 7) equals the top bit of `result_o`.
- R5: With D (status bit 3) set and valid BCD inputs, ADC gives the packed BCD digits of (acc + operand + C) mod 100. C is set exactly when that decimal sum reaches 100.
- R6: In decimal mode, Z and N are taken from the corrected BCD result. V is taken from the binary sum before correction.
- R7: SEC (code 3) sets C, SED (code 4) sets D and SEI (code 5) sets I (status bit 2). All other flags keep their values.
- R8: BRK (code 6) sets I and B (status bit 4). `push_o` always equals `status_o` with bits 4 and 5 forced to 1.
- R9: After reset, `status_o` reads 0x24: I is set, bit 5 reads 1, and every other bit is 0.
- R10: While `en` is low, `status_o` does not change, whatever the command.
- R11: LDF (code 2) sets Z and N from the operand and leaves C and V unchanged. For every command other than ADC, `result_o` equals the operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Command enable, sampled on the rising edge |
| op | input | 3 | Command: 0 none, 1 ADC, 2 LDF, 3 SEC, 4 SED, 5 SEI, 6 BRK |
| acc_in | input | DATA_W | Accumulator operand |
| opnd_in | input | DATA_W | Second operand, or the load value for LDF |
| result_o | output | DATA_W | Sum for ADC, otherwise the operand |
| status_o | output | 8 | Status byte N V 1 B D I Z C, from bit 7 down to bit 0 |
| push_o | output | 8 | Status byte as written by a break, with B and bit 5 set |

## Verification
The bench builds the unit with its default DATA_W of 8. At that width there are two BCD digits, so the carry between the digits, the wrap from 99 to 00 and the final decimal carry into C can all be reached with ordinary vectors. Binary vectors cover signed overflow in both directions and the carry out of 0xFF. Decimal vectors are chosen so that the binary sum overflows while the corrected result is zero or positive, which separates the source of V from the source of Z and N.

// File: rtl/flag_bcd_alu_pkg.sv
package flag_bcd_alu_pkg;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_ADC  = 3'd1,
    CMD_LDF  = 3'd2,
    CMD_SEC  = 3'd3,
    CMD_SED  = 3'd4,
    CMD_SEI  = 3'd5,
    CMD_BRK  = 3'd6
  } alu_cmd_e;

  localparam int STATUS_W = 8;
  localparam int BIT_B    = 4;
  localparam int BIT_ONE  = 5;

  typedef struct packed {
    logic neg;
    logic ovf;
    logic brk;
    logic dec;
    logic irq_off;
    logic zero;
    logic carry;
  } flags_t;

  localparam flags_t FLAGS_AT_RESET = '{neg: 1'b0, ovf: 1'b0, brk: 1'b0,
                                        dec: 1'b0, irq_off: 1'b1,
                                        zero: 1'b0, carry: 1'b0};

  function automatic logic [STATUS_W-1:0] pack_status(input flags_t f);
    return {f.neg, f.ovf, 1'b1, f.brk, f.dec, f.irq_off, f.zero, f.carry};
  endfunction

endpackage

// File: rtl/alu_reset_sync.sv
module alu_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/alu_digit_adder.sv
module alu_digit_adder #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              decimal_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o,
  output logic              ovf_o
);
  localparam int DIGITS = DATA_W / 4;
  localparam int MSB    = DATA_W - 1;

  logic [DATA_W:0]   bin_full;
  logic [DATA_W-1:0] dec_sum;
  logic [DIGITS:0]   dig_carry;

  // Binary path, also the source of V in both modes
  assign bin_full = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};

  assign dig_carry[0] = cin_i;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [4:0] raw;
    logic [4:0] adj;
    logic       fix;
    assign raw = {1'b0, a_i[4*g +: 4]} + {1'b0, b_i[4*g +: 4]} + {4'b0, dig_carry[g]};
    assign fix = (raw > 5'd9);
    assign adj = raw + 5'd6;
    assign dec_sum[4*g +: 4] = fix ? adj[3:0] : raw[3:0];
    assign dig_carry[g+1]    = fix;
  end

  always_comb begin
    if (decimal_i) begin
      sum_o  = dec_sum;
      cout_o = dig_carry[DIGITS];
    end else begin
      sum_o  = bin_full[DATA_W-1:0];
      cout_o = bin_full[DATA_W];
    end
    ovf_o = (a_i[MSB] == b_i[MSB]) && (bin_full[MSB] != a_i[MSB]);
  end

  function automatic logic digits_ok(input logic [DATA_W-1:0] x);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < DIGITS; k++) begin
      if (x[4*k +: 4] > 4'd9) ok = 1'b0;
    end
    return ok;
  endfunction

  // R5: valid BCD inputs give valid BCD digits
  p_digit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (decimal_i && digits_ok(a_i) && digits_ok(b_i)) |-> digits_ok(sum_o));

  // R3: binary overflow flips the sign relative to like-signed inputs
  p_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!decimal_i && ovf_o) |-> (sum_o[MSB] != a_i[MSB]));

  // R1: binary carry never comes with a larger result than either input when both are below half range
  p_nocarry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!decimal_i && !a_i[MSB] && !b_i[MSB]) |-> !cout_o);
endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg
  import flag_bcd_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  alu_cmd_e            cmd_i,
  input  logic [DATA_W-1:0]   sum_i,
  input  logic                cout_i,
  input  logic                ovf_i,
  input  logic [DATA_W-1:0]   load_i,
  output flags_t              flags_o
);
  localparam int MSB = DATA_W - 1;

  flags_t flags_q;
  flags_t flags_d;

  always_comb begin
    flags_d = flags_q;
    unique case (cmd_i)
      CMD_ADC: begin
        flags_d.carry = cout_i;
        flags_d.zero  = (sum_i == '0);
        flags_d.neg   = sum_i[MSB];
        flags_d.ovf   = ovf_i;
      end
      CMD_LDF: begin
        flags_d.zero = (load_i == '0);
        flags_d.neg  = load_i[MSB];
      end
      CMD_SEC: flags_d.carry   = 1'b1;
      CMD_SED: flags_d.dec     = 1'b1;
      CMD_SEI: flags_d.irq_off = 1'b1;
      CMD_BRK: begin
        flags_d.irq_off = 1'b1;
        flags_d.brk     = 1'b1;
      end
      default: flags_d = flags_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= FLAGS_AT_RESET;
    end else if (en_i) begin
      flags_q <= flags_d;
    end
  end

  assign flags_o = flags_q;

  p_carry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && cmd_i == CMD_ADC) |=> (flags_q.carry == $past(cout_i)));

  p_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && cmd_i == CMD_ADC) |=> (flags_q.zero == ($past(sum_i) == '0)));

  p_neg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && cmd_i == CMD_ADC) |=> (flags_q.neg == $past(sum_i[MSB])));

  p_sec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && cmd_i == CMD_SEC) |=> (flags_q.carry && $stable(flags_q.zero)));

  p_sed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && cmd_i == CMD_SED) |=> (flags_q.dec && $stable(flags_q.carry)));

  p_brk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && cmd_i == CMD_BRK) |=> (flags_q.brk && flags_q.irq_off));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(flags_q));

  p_ldf_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && cmd_i == CMD_LDF) |=> ($stable(flags_q.carry) && $stable(flags_q.ovf)));
endmodule

// File: rtl/alu_push_format.sv
module alu_push_format
  import flag_bcd_alu_pkg::*;
(
  input  flags_t              flags_i,
  output logic [STATUS_W-1:0] status_o,
  output logic [STATUS_W-1:0] push_o
);
  logic [STATUS_W-1:0] packed_st;

  always_comb begin
    packed_st         = pack_status(flags_i);
    status_o          = packed_st;
    push_o            = packed_st;
    push_o[BIT_B]     = 1'b1;
    push_o[BIT_ONE]   = 1'b1;
  end
endmodule

// File: rtl/flag_bcd_alu.sv
module flag_bcd_alu
  import flag_bcd_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] opnd_in,
  output logic [DATA_W-1:0] result_o,
  output logic [7:0]        status_o,
  output logic [7:0]        push_o
);
  logic              srst_n;
  alu_cmd_e          cmd;
  flags_t            flags;
  logic [DATA_W-1:0] add_sum;
  logic              add_cout;
  logic              add_ovf;

  assign cmd = alu_cmd_e'(op);

  alu_reset_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  alu_digit_adder #(.DATA_W(DATA_W)) u_add (
    .clk       (clk),
    .rst_n     (srst_n),
    .a_i       (acc_in),
    .b_i       (opnd_in),
    .cin_i     (flags.carry),
    .decimal_i (flags.dec),
    .sum_o     (add_sum),
    .cout_o    (add_cout),
    .ovf_o     (add_ovf)
  );

  alu_status_reg #(.DATA_W(DATA_W)) u_st (
    .clk     (clk),
    .rst_n   (srst_n),
    .en_i    (en),
    .cmd_i   (cmd),
    .sum_i   (add_sum),
    .cout_i  (add_cout),
    .ovf_i   (add_ovf),
    .load_i  (opnd_in),
    .flags_o (flags)
  );

  alu_push_format u_fmt (
    .flags_i  (flags),
    .status_o (status_o),
    .push_o   (push_o)
  );

  always_comb begin
    result_o = (cmd == CMD_ADC) ? add_sum : opnd_in;
  end

  // R11: non-add commands pass the operand through
  p_pass_r11: assert property (@(posedge clk) disable iff (!srst_n)
    (cmd != CMD_ADC) |-> (result_o == opnd_in));
endmodule

// File: tb/flag_bcd_alu_tb_top.sv
`timescale 1ns/1ps
module flag_bcd_alu_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [2:0] op;
  logic [7:0] acc_in, opnd_in;
  logic [7:0] result_o, status_o, push_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  // Bench-side expected flags
  bit e_n, e_v, e_b, e_d, e_i, e_z, e_c;

  always #10 clk = ~clk;

  flag_bcd_alu #(.DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op),
    .acc_in(acc_in), .opnd_in(opnd_in),
    .result_o(result_o), .status_o(status_o), .push_o(push_o)
  );

  function automatic logic [7:0] exp_status();
    return {e_n, e_v, 1'b1, e_b, e_d, e_i, e_z, e_c};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    en = 1'b0; op = 3'd0; acc_in = 8'h00; opnd_in = 8'h00;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    e_n = 0; e_v = 0; e_b = 0; e_d = 0; e_i = 1; e_z = 0; e_c = 0;
  endtask

  // Apply one enabled command; returns combinational result seen in that cycle
  task automatic run_cmd(input logic [2:0] c, input logic [7:0] a, input logic [7:0] b,
                         output logic [7:0] res);
    @(negedge clk);
    op = c; acc_in = a; opnd_in = b; en = 1'b1;
    #1 res = result_o;
    @(negedge clk);
    en = 1'b0; op = 3'd0;
  endtask

  function automatic int bcd_val(input logic [7:0] x);
    return int'(x[7:4]) * 10 + int'(x[3:0]);
  endfunction

  task automatic adc_check(input string tag, input logic [7:0] a, input logic [7:0] b);
    logic [7:0] res, exp_r;
    int s, ss;
    ss = int'($signed(a)) + int'($signed(b)) + int'(e_c);
    if (e_d) begin
      s     = bcd_val(a) + bcd_val(b) + int'(e_c);
      exp_r = {4'((s % 100) / 10), 4'(s % 10)};
      e_c   = (s >= 100);
    end else begin
      s     = int'(a) + int'(b) + int'(e_c);
      exp_r = 8'(s);
      e_c   = (s > 255);
    end
    e_v = (ss > 127) || (ss < -128);
    e_z = (exp_r == 8'h00);
    e_n = exp_r[7];
    run_cmd(3'd1, a, b, res);
    check({tag, " result"}, res, exp_r);
    check({tag, " status"}, status_o, exp_status());
  endtask

  task automatic t_reset();
    do_reset();
    check("R9 reset status", status_o, 8'h24);
    check("R8 push after reset", push_o, 8'h34);
  endtask

  task automatic t_enable_low();
    do_reset();
    @(negedge clk);
    en = 1'b0; op = 3'd3; acc_in = 8'hFF; opnd_in = 8'h01;
    @(negedge clk);
    check("R10 SEC without enable", status_o, 8'h24);
    op = 3'd1;
    @(negedge clk);
    check("R10 ADC without enable", status_o, 8'h24);
    op = 3'd4;
    @(negedge clk);
    op = 3'd0;
    check("R10 SED without enable", status_o, 8'h24);
  endtask

  task automatic t_binary();
    do_reset();
    adc_check("R1 plain 12+34", 8'h12, 8'h34);
    adc_check("R3 R4 overflow 40+40", 8'h40, 8'h40);
    adc_check("R1 R2 wrap FF+01", 8'hFF, 8'h01);
    adc_check("R1 carry-in 10+20", 8'h10, 8'h20);
    adc_check("R3 negative overflow 80+80", 8'h80, 8'h80);
    adc_check("R1 carry-in after wrap 7F+00", 8'h7F, 8'h00);
  endtask

  task automatic t_decimal();
    logic [7:0] r;
    do_reset();
    run_cmd(3'd4, 8'h00, 8'h00, r);
    e_d = 1;
    check("R7 SED sets D", status_o, exp_status());
    adc_check("R5 digits 19+28", 8'h19, 8'h28);
    adc_check("R5 R6 carry 58+46", 8'h58, 8'h46);
    adc_check("R5 wrap 99+00+C", 8'h99, 8'h00);
    adc_check("R6 zero 50+49+C", 8'h50, 8'h49);
    adc_check("R6 N from result 40+45", 8'h40, 8'h45);
    adc_check("R6 V binary 50+50", 8'h50, 8'h50);
  endtask

  task automatic t_set_brk();
    logic [7:0] r;
    do_reset();
    run_cmd(3'd3, 8'h00, 8'h00, r);
    e_c = 1;
    check("R7 SEC status", status_o, exp_status());
    check("R8 push forces bit4", push_o, 8'h35);
    run_cmd(3'd5, 8'h00, 8'h00, r);
    check("R7 SEI keeps others", status_o, exp_status());
    run_cmd(3'd6, 8'h00, 8'h00, r);
    e_b = 1; e_i = 1;
    check("R8 BRK status", status_o, 8'h35);
    check("R8 BRK push", push_o, 8'h35);
  endtask

  task automatic t_load();
    logic [7:0] r;
    do_reset();
    run_cmd(3'd3, 8'h00, 8'h00, r);
    e_c = 1;
    run_cmd(3'd2, 8'hAA, 8'h00, r);
    e_z = 1; e_n = 0;
    check("R11 LDF zero result", r, 8'h00);
    check("R11 LDF zero status", status_o, exp_status());
    run_cmd(3'd2, 8'h00, 8'h90, r);
    e_z = 0; e_n = 1;
    check("R11 LDF neg result", r, 8'h90);
    check("R11 LDF neg status", status_o, exp_status());
    adc_check("R3 set V 40+3F+C", 8'h40, 8'h3F);
    run_cmd(3'd2, 8'h00, 8'h01, r);
    e_z = 0; e_n = 0;
    check("R11 LDF keeps V and C", status_o, exp_status());
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; op = 3'd0; acc_in = 8'h00; opnd_in = 8'h00;
    t_reset();
    t_enable_low();
    t_binary();
    t_decimal();
    t_set_brk();
    t_load();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule